// File: doc/BRIEF.md
# Transmit Amplifier Power Ramp Controller

This block produces the 6-bit drive code for a transmit power amplifier. Switching the amplifier abruptly disturbs the oscillator that feeds it and spreads energy around the carrier. To avoid that, the code walks gradually between zero and a programmed power level instead of stepping there at once. The walk runs on the system clock. A strobe marks the start of each data bit, and a 3-bit rate setting selects how many single-code steps fall into one bit period. The steps are spaced evenly across the period.

Two controls turn the amplifier on. The amplifier enable bit ramps the code up when it is set, but clearing it forces the code to zero on the next edge and raises a power-down flag. The transmit mode bit ramps the code up when it is set and ramps it back down to zero when it is cleared. The code only moves when both are set, or while it is ramping down under transmit mode. Status outputs report when a ramp finishes, when the code sits at its target, and when a ramp is in progress. The bit period in system clocks is a power-of-two parameter of at least 256; the default is 512.

Top module: `pa_ramp_top`

## Requirements
- R1: While `rst` is high, the design registers are cleared at each edge: `driveCode` = 0, `rampDone` = 0, `atTarget` = 0, `rampActive` = 0, `pwrDown` = 1, and the bit-phase counter is 0.
- R2: While `paEn` and `txMode` are both 1 and `rampRate` is not 0, each step moves `driveCode` by exactly one code toward `targetCode`. The code never passes `targetCode`, and once it equals `targetCode` it holds.
- R3: With `rampRate` = 0 and both `paEn` and `txMode` at 1, `driveCode` equals `targetCode` after the next clock edge.
- R4: The bit phase is 0 in the cycle after a `bitStrobe` or reset and counts up by one per clock, modulo CLKS_PER_BIT. For `rampRate` = r in 1..7, let I = CLKS_PER_BIT >> (9 - r). A step happens only at an edge where the phase modulo I equals I - 1. This gives 256 >> (r - 1) steps per bit period: 256, 128, 64, 32, 16, 8 and 4 for settings 1 to 7.
- R5: If `paEn` is 0 at an edge, then after that edge `driveCode` = 0, `pwrDown` = 1, `rampDone` = 0 and `rampActive` = 0, whatever the other inputs are. If `paEn` is 1 at an edge, `pwrDown` = 0 after it.
- R6: With `paEn` = 1 and `txMode` = 0, a nonzero `driveCode` falls by one code per step (timed as in R4) until it reaches 0. With `rampRate` = 0 it drops to 0 after the next edge.
- R7: Changing direction partway through a ramp, in either direction, continues from the current code without a jump. The next change of the code is a single step.
- R8: `rampDone` is 1 for exactly the one cycle after the edge at which the code lands on its end point: `targetCode` when ramping up, 0 when ramping down. It is 0 in every other cycle.
- R9: After each edge, `atTarget` is 1 exactly when `paEn` and `txMode` were 1 at that edge and the new `driveCode` equals the `targetCode` that was applied at that edge.
- R10: After each edge, `rampActive` is 1 exactly when `paEn` was 1 and the new code still differs from its end point. The end point is `targetCode` if `txMode` was 1, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| bitStrobe | input | 1 | One-cycle pulse marking the start of a data bit period |
| paEn | input | 1 | Amplifier enable; clearing it cuts the code at once |
| txMode | input | 1 | Transmit mode; setting ramps up, clearing ramps down |
| rampRate | input | 3 | Ramp rate setting, 0 = no ramp, 1..7 = 256..4 steps per bit |
| targetCode | input | 6 | Target drive code when fully on |
| driveCode | output | 6 | Current amplifier drive code |
| rampDone | output | 1 | One-cycle pulse when a ramp reaches its end point |
| atTarget | output | 1 | Code is at the target while transmitting |
| rampActive | output | 1 | A ramp is under way |
| pwrDown | output | 1 | Output stage powered down |

## Verification
The hardest state to reach from the ports is a reversal in the middle of a ramp. It has to land at a known bit phase, so that the number of steps in the following window can be predicted. The stimulus keeps `bitStrobe` locked to a bench phase counter and drops transmit mode once the code has reached a chosen middle value. It then counts the exact steps that follow. Long random segments also change the enable, mode, rate and target at arbitrary phases. A reference model computed from the requirements checks every output in every cycle, including stray strobes that realign the phase.

// File: rtl/pa_ramp_pkg.sv
package pa_ramp_pkg;
  localparam int RATE_W       = 3;  // width of the ramp rate setting
  localparam int STEP_LOG_MAX = 8;  // log2 of steps per bit at the fastest ramping setting

  typedef enum logic [1:0] {ST_IDLE, ST_UP, ST_HOLD, ST_DOWN} rampState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic clear;
    logic load;
    logic stepUp;
    logic stepDown;
  } dpCtl_t;
endpackage

// File: rtl/pa_ramp_tick.sv
module pa_ramp_tick
  import pa_ramp_pkg::*;
#(
  parameter int CLKS_PER_BIT = 512
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bitStrobe,
  input  logic [RATE_W-1:0] rampRate,
  output logic              stepTick
);
  localparam int PH_W = $clog2(CLKS_PER_BIT);

  logic [PH_W-1:0] phase;
  logic [PH_W-1:0] stepMask;
  int              shiftAmt;

  always_ff @(posedge clk) begin
    if (rst)            phase <= '0;
    else if (bitStrobe) phase <= '0;
    else                phase <= phase + 1'b1;
  end

  // step interval = CLKS_PER_BIT / (256 >> (rate-1)), always a power of two
  always_comb begin
    shiftAmt = 0;
    if (rampRate != '0) shiftAmt = PH_W - STEP_LOG_MAX + int'(rampRate) - 1;
    stepMask = (PH_W'(1) << shiftAmt) - PH_W'(1);
    stepTick = (phase & stepMask) == stepMask;
  end
endmodule

// File: rtl/pa_ramp_dp.sv
module pa_ramp_dp
  import pa_ramp_pkg::*;
#(
  parameter int CODE_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  dpCtl_t            ctl,
  input  logic [CODE_W-1:0] targetCode,
  output logic [CODE_W-1:0] driveCode,
  output logic              codeEq,
  output logic              codeBelow,
  output logic              distOne,
  output logic              codeIsOne,
  output logic              codeIsZero
);
  logic [CODE_W:0] codeExt, targetExt;

  always_ff @(posedge clk) begin
    if (rst)               driveCode <= '0;
    else if (ctl.clear)    driveCode <= '0;
    else if (ctl.load)     driveCode <= targetCode;
    else if (ctl.stepUp)   driveCode <= driveCode + 1'b1;
    else if (ctl.stepDown) driveCode <= driveCode - 1'b1;
  end

  always_comb begin
    codeExt    = {1'b0, driveCode};
    targetExt  = {1'b0, targetCode};
    codeEq     = driveCode == targetCode;
    codeBelow  = driveCode < targetCode;
    distOne    = (codeExt + 1'b1 == targetExt) || (targetExt + 1'b1 == codeExt);
    codeIsOne  = driveCode == CODE_W'(1);
    codeIsZero = driveCode == '0;
  end
endmodule

// File: rtl/pa_ramp_fsm.sv
module pa_ramp_fsm
  import pa_ramp_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              paEn,
  input  logic              txMode,
  input  logic [RATE_W-1:0] rampRate,
  input  logic              stepTick,
  input  logic              codeEq,
  input  logic              codeBelow,
  input  logic              distOne,
  input  logic              codeIsOne,
  input  logic              codeIsZero,
  output dpCtl_t            ctl,
  output logic              rampDone,
  output logic              atTarget,
  output logic              rampActive,
  output logic              pwrDown
);
  rampState_t state, nxt;
  logic       landing;
  logic       noRamp;

  assign noRamp = rampRate == '0;

  always_comb begin
    ctl     = '0;
    nxt     = state;
    landing = 1'b0;
    if (!paEn) begin
      ctl.clear = 1'b1;
      nxt       = ST_IDLE;
    end else if (txMode) begin
      if (codeEq) begin
        nxt = ST_HOLD;
      end else begin
        nxt = ST_UP;
        if (noRamp) begin
          ctl.load = 1'b1;
          landing  = 1'b1;
          nxt      = ST_HOLD;
        end else if (stepTick) begin
          ctl.stepUp   = codeBelow;
          ctl.stepDown = !codeBelow;
          if (distOne) begin
            landing = 1'b1;
            nxt     = ST_HOLD;
          end
        end
      end
    end else begin
      if (codeIsZero) begin
        nxt = ST_IDLE;
      end else begin
        nxt = ST_DOWN;
        if (noRamp) begin
          ctl.clear = 1'b1;
          landing   = 1'b1;
          nxt       = ST_IDLE;
        end else if (stepTick) begin
          ctl.stepDown = 1'b1;
          if (codeIsOne) begin
            landing = 1'b1;
            nxt     = ST_IDLE;
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      rampDone <= 1'b0;
      pwrDown  <= 1'b1;
    end else begin
      state    <= nxt;
      rampDone <= landing;
      pwrDown  <= !paEn;
    end
  end

  assign atTarget   = state == ST_HOLD;
  assign rampActive = (state == ST_UP) || (state == ST_DOWN);
endmodule

// File: rtl/pa_ramp_top.sv
module pa_ramp_top
  import pa_ramp_pkg::*;
#(
  parameter int CODE_W       = 6,
  parameter int CLKS_PER_BIT = 512
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bitStrobe,
  input  logic              paEn,
  input  logic              txMode,
  input  logic [RATE_W-1:0] rampRate,
  input  logic [CODE_W-1:0] targetCode,
  output logic [CODE_W-1:0] driveCode,
  output logic              rampDone,
  output logic              atTarget,
  output logic              rampActive,
  output logic              pwrDown
);
  dpCtl_t ctl;
  logic   stepTick, codeEq, codeBelow, distOne, codeIsOne, codeIsZero;

  pa_ramp_tick #(.CLKS_PER_BIT(CLKS_PER_BIT)) u_tick (
    .clk(clk), .rst(rst), .bitStrobe(bitStrobe), .rampRate(rampRate), .stepTick(stepTick)
  );

  pa_ramp_fsm u_fsm (
    .clk(clk), .rst(rst), .paEn(paEn), .txMode(txMode), .rampRate(rampRate),
    .stepTick(stepTick), .codeEq(codeEq), .codeBelow(codeBelow), .distOne(distOne),
    .codeIsOne(codeIsOne), .codeIsZero(codeIsZero), .ctl(ctl), .rampDone(rampDone),
    .atTarget(atTarget), .rampActive(rampActive), .pwrDown(pwrDown)
  );

  pa_ramp_dp #(.CODE_W(CODE_W)) u_dp (
    .clk(clk), .rst(rst), .ctl(ctl), .targetCode(targetCode), .driveCode(driveCode),
    .codeEq(codeEq), .codeBelow(codeBelow), .distOne(distOne), .codeIsOne(codeIsOne),
    .codeIsZero(codeIsZero)
  );
endmodule

// File: rtl/pa_ramp_chk.sv
module pa_ramp_chk #(
  parameter int CODE_W = 6
) (
  input logic              clk,
  input logic              rst,
  input logic              paEn,
  input logic              txMode,
  input logic [2:0]        rampRate,
  input logic [CODE_W-1:0] targetCode,
  input logic [CODE_W-1:0] driveCode,
  input logic              rampDone,
  input logic              pwrDown
);
  AST_OFF_CUTS_CODE: assert property (@(posedge clk) disable iff (rst)
    !paEn |=> (driveCode == '0 && pwrDown && !rampDone)); // R5

  AST_ON_CLEARS_PD: assert property (@(posedge clk) disable iff (rst)
    paEn |=> !pwrDown); // R5

  AST_SINGLE_STEP: assert property (@(posedge clk) disable iff (rst)
    (paEn && rampRate != 3'd0) |=> (driveCode == $past(driveCode) ||
      driveCode == $past(driveCode) + 1'b1 || driveCode == $past(driveCode) - 1'b1)); // R2

  AST_HOLD_AT_TARGET: assert property (@(posedge clk) disable iff (rst)
    (paEn && txMode && driveCode == targetCode) |=> $stable(driveCode)); // R2

  AST_NO_RAMP_JUMP: assert property (@(posedge clk) disable iff (rst)
    (paEn && txMode && rampRate == 3'd0) |=> driveCode == $past(targetCode)); // R3

  AST_DOWN_NOT_UP: assert property (@(posedge clk) disable iff (rst)
    (paEn && !txMode && rampRate != 3'd0) |=> driveCode <= $past(driveCode)); // R6

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    rampDone |=> !rampDone); // R8
endmodule

bind pa_ramp_top pa_ramp_chk #(.CODE_W(CODE_W)) u_chk (
  .clk(clk), .rst(rst), .paEn(paEn), .txMode(txMode), .rampRate(rampRate),
  .targetCode(targetCode), .driveCode(driveCode), .rampDone(rampDone), .pwrDown(pwrDown)
);

// File: tb/sim_pa_ramp_top.sv
module sim_pa_ramp_top;
  localparam int CLK_PERIOD = 10;
  localparam int CLKS       = 512;
  localparam int CW         = 6;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          bitStrobe = 1'b0;
  logic          paEn = 1'b0;
  logic          txMode = 1'b0;
  logic [2:0]    rampRate = 3'd0;
  logic [CW-1:0] targetCode = '0;
  logic [CW-1:0] driveCode;
  logic          rampDone, atTarget, rampActive, pwrDown;

  int total = 0;
  int bad   = 0;
  bit finished = 0;

  // reference model state
  int mCode = 0, mPh = 0;
  bit mDone = 0, mAt = 0, mBusy = 0, mPd = 1;

  pa_ramp_top #(.CODE_W(CW), .CLKS_PER_BIT(CLKS)) u0 (
    .clk(clk), .rst(rst), .bitStrobe(bitStrobe), .paEn(paEn), .txMode(txMode),
    .rampRate(rampRate), .targetCode(targetCode), .driveCode(driveCode),
    .rampDone(rampDone), .atTarget(atTarget), .rampActive(rampActive), .pwrDown(pwrDown)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // expected values after one edge, from the requirements
  task automatic modelEdge();
    int  sh, mask, nc, tgt;
    bit  tick, moved;
    if (rst) begin
      mCode = 0; mPh = 0; mDone = 0; mAt = 0; mBusy = 0; mPd = 1;  // R1
    end else begin
      tgt   = int'(targetCode);
      sh    = (rampRate == 0) ? 0 : int'(rampRate);   // log2(CLKS)=9: I = 512 >> (9-r)
      mask  = (1 << sh) - 1;
      tick  = (mPh & mask) == mask;                    // R4
      nc    = mCode;
      moved = 0;
      if (!paEn) nc = 0;                               // R5
      else if (txMode) begin
        if (mCode != tgt) begin
          if (rampRate == 0) begin nc = tgt; moved = 1; end
          else if (tick) begin nc = (mCode < tgt) ? mCode + 1 : mCode - 1; moved = 1; end
        end
      end else if (mCode != 0) begin
        if (rampRate == 0) begin nc = 0; moved = 1; end
        else if (tick) begin nc = mCode - 1; moved = 1; end
      end
      mDone = moved && (txMode ? (nc == tgt) : (nc == 0));
      mAt   = paEn && txMode && nc == tgt;
      mBusy = paEn && (txMode ? nc != tgt : nc != 0);
      mPd   = !paEn;
      mCode = nc;
      mPh   = bitStrobe ? 0 : (mPh + 1) % CLKS;
    end
  endtask

  function automatic string codeTag();
    if (!paEn)              return "R5";
    else if (rampRate == 0) return "R3";
    else if (!txMode)       return "R6";
    else                    return "R2";
  endfunction

  // one clock: model the edge just passed, compare, then set the strobe
  task automatic step(input bit extraStrobe = 0);
    @(negedge clk);
    modelEdge();
    if (!rst) begin
      check(int'(driveCode) == mCode, codeTag(), int'(driveCode), mCode);
      check(rampDone == mDone, "R8", int'(rampDone), int'(mDone));
      check(atTarget == mAt, "R9", int'(atTarget), int'(mAt));
      check(rampActive == mBusy, "R10", int'(rampActive), int'(mBusy));
      check(pwrDown == mPd, "R5", int'(pwrDown), int'(mPd));
    end
    bitStrobe = (mPh == CLKS - 1) || extraStrobe;
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic setIn(input bit en, input bit tx, input int rate, input int tgt);
    paEn = en; txMode = tx; rampRate = 3'(rate); targetCode = CW'(tgt);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int c0;
    void'($urandom(32'h5eed_0a11));
    rst = 1'b1;
    run(4);
    @(negedge clk);
    // R1: reset state
    check(driveCode == '0, "R1", int'(driveCode), 0);
    check(pwrDown == 1'b1, "R1", int'(pwrDown), 1);
    check(rampDone == 1'b0 && atTarget == 1'b0 && rampActive == 1'b0, "R1",
          int'({rampDone, atTarget, rampActive}), 0);
    rst = 1'b0;
    run(3);

    // R4: rate 4 gives 32 steps in one bit period
    setIn(1, 1, 4, 63);
    run(CLKS);
    check(int'(driveCode) == 32, "R4", int'(driveCode), 32);
    // R6 with rate 0: drop to zero at once
    setIn(1, 0, 0, 63);
    step();
    check(driveCode == '0 && rampDone, "R6", int'(driveCode), 0);

    // R4: rate 7 gives 4 steps per bit
    setIn(1, 1, 7, 63);
    run(CLKS);
    check(int'(driveCode) == 4, "R4", int'(driveCode), 4);
    setIn(0, 0, 7, 63);
    step();

    // R3: no-ramp jump with done and at-target
    setIn(1, 1, 0, 37);
    step();
    check(int'(driveCode) == 37, "R3", int'(driveCode), 37);
    check(rampDone && atTarget, "R8", int'({rampDone, atTarget}), 3);
    step();
    check(!rampDone && atTarget, "R9", int'({rampDone, atTarget}), 1);

    // R7: reverse a rising ramp at rate 1 (one step every 2 clocks)
    setIn(0, 0, 1, 40);
    step();
    setIn(1, 1, 1, 40);
    while (int'(driveCode) != 20) step();
    setIn(1, 0, 1, 40);
    c0 = int'(driveCode);
    run(10);
    check(int'(driveCode) == c0 - 5, "R7", int'(driveCode), c0 - 5);
    setIn(1, 1, 1, 40);
    run(4);
    check(int'(driveCode) == c0 - 3, "R7", int'(driveCode), c0 - 3);

    // R5: cutting enable mid ramp zeroes the code at once
    setIn(0, 1, 1, 40);
    step();
    check(driveCode == '0 && pwrDown && !rampDone, "R5", int'(driveCode), 0);

    // R2: full ramp to 63 at rate 2 settles and holds
    setIn(1, 1, 2, 63);
    run(300);
    check(int'(driveCode) == 63 && atTarget, "R2", int'(driveCode), 63);
    run(50);
    check(int'(driveCode) == 63, "R2", int'(driveCode), 63);

    // constrained random segments, with occasional stray strobes
    for (int seg = 0; seg < 70; seg++) begin
      int len;
      setIn(($urandom % 8) != 0, ($urandom % 4) != 0, int'($urandom % 8), int'($urandom % 64));
      len = 100 + int'($urandom % 1500);
      for (int k = 0; k < len; k++) step(($urandom % 700) == 0);
    end

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule